// File: doc/BRIEF.md
# BLDC Gate PWM Steering Mask

This block takes one PWM carrier and routes it onto the six gate-drive lines of a three-phase bridge. There are three high-side lines and three low-side lines. A six-bit commutation pattern, supplied by an external sequencer, picks the high-side and low-side switch that conduct in the present sector. A control byte then decides four things: which arm carries the PWM, whether PWM is applied at all, whether the opposite switch of the modulated phase is driven with the inverted carrier, and whether that last choice is global or set per phase.

A programmable dead band keeps the two switches of one phase from conducting together. A fault input forces a safe output state. The forced state is held until software clears it. A small register port gives write and read access to the control byte, the per-phase drive mode, and the dead time. It also gives read access to a status byte that reports three gate lines and the filtered Hall inputs.

Top module: `bldc_gate_steer`

## Requirements
- R1: After a synchronous reset the control byte reads 0x04, the per-phase mode and dead-time registers read 0, and all six gate outputs are 0.
- R2: Registers sit at address 0 (control), 1 (per-phase mode, bits 2:0, phase A in bit 0), 2 (dead time) and 3 (status). A read returns its data one clock after the address is presented. Control bits 6:4 and mode bits 7:3 always read 0.
- R3: Control bit 0 picks the modulated arm. When it is 0, the selected low-side switch carries the PWM and the selected high-side switch is held fully on. When it is 1, the roles swap. Outputs are registered and follow the inputs one clock later.
- R4: When control bit 2 (PWM enable) is 0, every selected switch is driven fully on and no inverted carrier appears on any line.
- R5: With control bit 7 at 0 (global mode), control bit 3 applies to every phase. A value of 0 drives the opposite switch of each modulated phase with the inverted carrier. A value of 1 holds that opposite switch off.
- R6: With control bit 7 at 1 (per-phase mode), bit p of register 1 takes the place of control bit 3 for phase p, and control bit 3 is ignored.
- R7: The high-side and low-side outputs of one phase are never both 1.
- R8: A switch turns on only after the opposite switch of its phase has been off for the number of clocks held in register 2. A value of 0 allows an immediate hand-over.
- R9: A high level on fault_in latches protection asynchronously. From the next clock edge, all high-side outputs are 0 and all low-side outputs equal control bit 1. This state overrides every other mode, persists after fault_in falls, and ends only when software writes to address 3 with fault_in low.
- R10: commut bits 2:0 select the high-side switch of phases A, B and C; bits 5:3 select the low-side switch. A phase with neither bit or both bits set keeps both switches off.
- R11: The status byte at address 3 is {2'b00, high A, low A, high B, Hall C, Hall B, Hall A}, where hall_in bit 0 is Hall A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_in | input | 1 | Asynchronous protection request, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data |
| pwm_in | input | 1 | PWM carrier |
| commut | input | 6 | Commutation pattern: [2:0] high-side A..C, [5:3] low-side A..C |
| hall_in | input | 3 | Filtered Hall inputs, bit 0 = A |
| gate_hi | output | 3 | High-side gate drives, bit 0 = phase A |
| gate_lo | output | 3 | Low-side gate drives, bit 0 = phase A |

## Verification
A wrong mode decode shows on the gate lines one clock after the commutation pattern or carrier changes. It appears as a switch held on where it should chop, or as an inverted carrier where the line should stay off. A sweep over every control, mode and pattern combination therefore exposes it at once. A corrupted dead-band counter shows as a hand-over that arrives early or late by whole clocks, or as both switches of one phase on together in the same cycle. A stuck or early-cleared protection latch shows as a gate line that leaves its safe level before the clearing write, or that fails to return one clock after it.

// File: rtl/bldc_gs_pkg.sv
package bldc_gs_pkg;
  localparam int NPH    = 3;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] A_DEAD = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  // control byte; field order is decoded by software
  typedef struct packed {
    logic       sw_mask;   // 7: per-phase drive mode source
    logic [2:0] rsv;       // 6:4
    logic       indep;     // 3: 1 = non-complementary
    logic       pwm_en;    // 2
    logic       safe_lo;   // 1: low-side level under protection
    logic       hi_arm;    // 0: 1 = PWM on high side
  } ctrl_t;

  localparam logic [DATA_W-1:0] CTRL_RST = 8'h04;
endpackage

// File: rtl/gs_regs.sv
module gs_regs
  import bldc_gs_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] status,
  output ctrl_t             ctl,
  output logic [NPH-1:0]    ph_indep,
  output logic [DT_W-1:0]   dead,
  output logic              prot,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= ctrl_t'(CTRL_RST);
      ph_indep <= '0;
      dead     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          ctl     <= ctrl_t'(wr_data);
          ctl.rsv <= '0;
        end
        A_MODE:  ph_indep <= wr_data[NPH-1:0];
        A_DEAD:  dead     <= wr_data[DT_W-1:0];
        default: ;
      endcase
    end
  end

  // protection latch: set asynchronously, cleared by a write to the status address
  always_ff @(posedge clk or posedge fault_in) begin
    if (fault_in)
      prot <= 1'b1;
    else if (rst)
      prot <= 1'b0;
    else if (wr_en && wr_addr == A_STAT)
      prot <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else begin
      case (rd_addr)
        A_CTRL:  rd_data <= ctl;
        A_MODE:  rd_data <= DATA_W'(ph_indep);
        A_DEAD:  rd_data <= DATA_W'(dead);
        default: rd_data <= status;
      endcase
    end
  end
endmodule

// File: rtl/gs_phase_map.sv
module gs_phase_map
  import bldc_gs_pkg::*;
(
  input  ctrl_t ctl,
  input  logic  indep,
  input  logic  sel_hi,
  input  logic  sel_lo,
  input  logic  pwm,
  output logic  raw_hi,
  output logic  raw_lo
);
  logic chop, comp;

  always_comb begin
    chop   = ctl.pwm_en ? pwm : 1'b1;
    comp   = ctl.pwm_en && !indep;
    raw_hi = 1'b0;
    raw_lo = 1'b0;
    if (sel_hi && !sel_lo) begin
      raw_hi = ctl.hi_arm ? chop : 1'b1;
      raw_lo = ctl.hi_arm && comp && !pwm;
    end else if (sel_lo && !sel_hi) begin
      raw_lo = ctl.hi_arm ? 1'b1 : chop;
      raw_hi = !ctl.hi_arm && comp && !pwm;
    end
  end
endmodule

// File: rtl/gs_dead_band.sv
module gs_dead_band #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            force_safe,
  input  logic            safe_lo,
  input  logic [DT_W-1:0] dead,
  input  logic            raw_hi,
  input  logic            raw_lo,
  output logic            hi,
  output logic            lo
);
  localparam logic [DT_W-1:0] CNT_MAX = '1;

  logic [DT_W-1:0] hi_off, lo_off;   // clocks each switch has been off
  logic            hi_nx, lo_nx;

  always_comb begin
    if (force_safe) begin
      hi_nx = 1'b0;
      lo_nx = safe_lo;
    end else begin
      hi_nx = raw_hi && (lo_off >= dead);
      lo_nx = raw_lo && (hi_off >= dead);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi     <= 1'b0;
      lo     <= 1'b0;
      hi_off <= CNT_MAX;
      lo_off <= CNT_MAX;
    end else begin
      hi     <= hi_nx;
      lo     <= lo_nx;
      hi_off <= hi_nx ? '0 : ((hi_off == CNT_MAX) ? hi_off : hi_off + 1'b1);
      lo_off <= lo_nx ? '0 : ((lo_off == CNT_MAX) ? lo_off : lo_off + 1'b1);
    end
  end
endmodule

// File: rtl/bldc_gate_steer.sv
module bldc_gate_steer
  import bldc_gs_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pwm_in,
  input  logic [2*NPH-1:0]  commut,
  input  logic [NPH-1:0]    hall_in,
  output logic [NPH-1:0]    gate_hi,
  output logic [NPH-1:0]    gate_lo
);
  ctrl_t             ctl_q;
  logic [NPH-1:0]    ph_indep;
  logic [DT_W-1:0]   dead;
  logic              prot_q;
  logic [DATA_W-1:0] status;

  assign status = {2'b00, gate_hi[0], gate_lo[0], gate_hi[1], hall_in};

  gs_regs #(.DT_W(DT_W)) u_regs (
    .clk(clk), .rst(rst), .fault_in(fault_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .status(status),
    .ctl(ctl_q), .ph_indep(ph_indep), .dead(dead),
    .prot(prot_q), .rd_data(rd_data)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic raw_hi, raw_lo, indep;
    assign indep = ctl_q.sw_mask ? ph_indep[p] : ctl_q.indep;

    gs_phase_map u_map (
      .ctl(ctl_q), .indep(indep),
      .sel_hi(commut[p]), .sel_lo(commut[p+NPH]),
      .pwm(pwm_in), .raw_hi(raw_hi), .raw_lo(raw_lo)
    );

    gs_dead_band #(.DT_W(DT_W)) u_db (
      .clk(clk), .rst(rst),
      .force_safe(prot_q), .safe_lo(ctl_q.safe_lo),
      .dead(dead), .raw_hi(raw_hi), .raw_lo(raw_lo),
      .hi(gate_hi[p]), .lo(gate_lo[p])
    );
  end
endmodule

// File: rtl/gs_checker.sv
module gs_checker
  import bldc_gs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              fault_in,
  input logic [2*NPH-1:0]  commut,
  input logic [NPH-1:0]    gate_hi,
  input logic [NPH-1:0]    gate_lo,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              prot_q,
  input logic [DATA_W-1:0] ctl_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (gate_hi == '0 && gate_lo == '0 && ctl_q == CTRL_RST));

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_CTRL) |=> (rd_data[6:4] == 3'b000));

  // R7
  no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(gate_hi & gate_lo) == 0);

  // R9
  protect_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && fault_in) |=> (gate_hi == '0));

  // R9
  protect_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && fault_in) |=> (gate_lo == {NPH{$past(ctl_q[1])}}));

  // R9
  protect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_q && !fault_in) |=> (gate_hi == '0));

  for (genvar p = 0; p < NPH; p++) begin : g_idle
    // R10
    idle_phase_chk: assert property (@(posedge clk) disable iff (rst)
      (!prot_q && !fault_in && (commut[p] == commut[p+NPH]))
        |=> (!gate_hi[p] && !gate_lo[p]));
  end
endmodule

bind bldc_gate_steer gs_checker u_chk (
  .clk(clk), .rst(rst), .fault_in(fault_in), .commut(commut),
  .gate_hi(gate_hi), .gate_lo(gate_lo),
  .rd_addr(rd_addr), .rd_data(rd_data),
  .prot_q(prot_q), .ctl_q(ctl_q)
);

// File: tb/test_bldc_gate_steer.sv
module test_bldc_gate_steer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fault_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       pwm_in = 1'b0;
  logic [5:0] commut = '0;
  logic [2:0] hall_in = '0;
  logic [2:0] gate_hi, gate_lo;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bldc_gate_steer i_bldc_gate_steer (
    .clk(clk), .rst(rst), .fault_in(fault_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_in(pwm_in), .commut(commut), .hall_in(hall_in),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    tick();
    d = rd_data;
  endtask

  // expected {lo, hi} from the requirements (R3..R6, R10), no dead time
  function automatic logic [5:0] model(input logic [7:0] c, input logic [2:0] m,
                                       input logic [5:0] cm, input logic pwm);
    logic [2:0] h, l;
    h = '0; l = '0;
    for (int p = 0; p < 3; p++) begin
      logic ni, chop, inv;
      ni   = c[7] ? m[p] : c[3];
      chop = c[2] ? pwm : 1'b1;
      inv  = c[2] && !ni && !pwm;
      if (cm[p] && !cm[p+3]) begin
        h[p] = c[0] ? chop : 1'b1;
        l[p] = c[0] && inv;
      end else if (cm[p+3] && !cm[p]) begin
        l[p] = c[0] ? 1'b1 : chop;
        h[p] = !c[0] && inv;
      end
    end
    return {l, h};
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) tick();
    // R1 reset state
    chk("R1 gates", {2'b0, gate_lo, gate_hi}, 8'h00);
    rst = 1'b0;
    rd(2'd0, d); chk("R1 ctrl", d, 8'h04);
    rd(2'd1, d); chk("R1 mode", d, 8'h00);
    rd(2'd2, d); chk("R1 dead", d, 8'h00);

    // R2 register access
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 ctrl", d, 8'h8F);
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R2 mode", d, 8'h07);
    wr(2'd2, 8'hA5); rd(2'd2, d); chk("R2 dead", d, 8'hA5);
    wr(2'd2, 8'h00);

    // R3 R4 R5 R6 R10 sweep over modes, patterns and carrier
    for (int c = 0; c < 16; c++) begin
      for (int m = 0; m < 8; m++) begin
        logic [7:0] cv;
        cv = {c[3], 3'b000, c[2], c[1], 1'b0, c[0]};
        wr(2'd0, cv);
        wr(2'd1, 8'(m));
        for (int a = 0; a < 3; a++) begin
          for (int b = 0; b < 3; b++) begin
            for (int w = 0; w < 2; w++) begin
              string tag;
              commut = 6'((1 << a) | (8 << b));
              pwm_in = w[0];
              tick();
              tag = (a == b) ? "R10" : !cv[2] ? "R4" : cv[7] ? "R6" :
                    cv[0] ? "R3" : "R5";
              chk(tag, {2'b0, gate_lo, gate_hi}, {2'b0, model(cv, 3'(m), commut, pwm_in)});
            end
          end
        end
      end
    end
    commut = 6'b000000; tick();
    chk("R10 none", {2'b0, gate_lo, gate_hi}, 8'h00);

    // R11 status byte
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h04);
    commut = 6'b001010; pwm_in = 1'b1; hall_in = 3'b101;
    tick(); tick();
    rd(2'd3, d); chk("R11 status", d, 8'h1D);

    // R9 protection
    wr(2'd0, 8'h05);
    commut = 6'b010001; pwm_in = 1'b1;
    tick();
    fault_in = 1'b1;
    tick();
    chk("R9 forced lvl0", {2'b0, gate_lo, gate_hi}, 8'h00);
    wr(2'd0, 8'h07);
    tick();
    chk("R9 forced lvl1", {2'b0, gate_lo, gate_hi}, 8'h38);
    fault_in = 1'b0;
    for (int k = 0; k < 3; k++) begin
      pwm_in = k[0];
      tick();
      chk("R9 held", {2'b0, gate_lo, gate_hi}, 8'h38);
    end
    pwm_in = 1'b1;
    wr(2'd3, 8'h00);
    tick();
    chk("R9 released", {2'b0, gate_lo, gate_hi}, 8'h11);

    // R8 dead time of 3 clocks on phase A, PWM on high side, complementary
    wr(2'd2, 8'd3);
    wr(2'd0, 8'h05);
    commut = 6'b010001; pwm_in = 1'b1;
    repeat (6) tick();
    chk("R8 start", {6'b0, gate_lo[0], gate_hi[0]}, 8'h01);
    pwm_in = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk("R8 hi->lo", {6'b0, gate_lo[0], gate_hi[0]}, (k == 4) ? 8'h02 : 8'h00);
      chk("R7 overlap", {5'b0, gate_hi & gate_lo}, 8'h00);
    end
    pwm_in = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk("R8 lo->hi", {6'b0, gate_lo[0], gate_hi[0]}, (k == 4) ? 8'h01 : 8'h00);
      chk("R7 overlap", {5'b0, gate_hi & gate_lo}, 8'h00);
    end

    summary();
    $finish;
  end
endmodule